// File: doc/BRIEF.md
# Two-Port GPIO Event Interrupt Controller

This block watches a set of general-purpose input lines, arranged as two ports of sixteen pins each. Each line first passes through a two-flop synchronizer. The block then looks for a configured event on the line: a rising edge, a falling edge, either edge, a high level or a low level. When the event occurs, it sets a sticky per-line flag. The flags are masked by a per-line enable. Each port then has its own interrupt request output, which is the OR of that port's enabled flags.

Detection runs on every line at all times. No configuration switches it off, and a masked line still collects flags. For this reason, software changes a line's trigger first, then clears that line's flag, and only then sets its enable. Software controls the block through a small synchronous register port. There are three configuration registers, an enable register, and a write-one-to-clear status register. Bit n of each register belongs to line n. Port A uses bits 0 to 15 and port B uses bits 16 to 31.

Top module: `gpio_event_irq`

## Requirements
- R1: In reset, every register reads 0 and both interrupt requests are 0. Register offsets on `bus_addr` are: 0 edge-select, 1 both-edges, 2 polarity, 3 enable, 4 status. Any other offset reads 0.
- R2: With edge-select=1, both-edges=0 and polarity=1, a rising input sets the line's flag 3 clock edges after the input changes. A falling input sets nothing.
- R3: With edge-select=1, both-edges=0 and polarity=0, a falling input sets the flag 3 edges later. A rising input sets nothing.
- R4: With edge-select=1 and both-edges=1, either transition sets the flag, whatever the polarity bit holds.
- R5: With edge-select=0 and polarity=1, a high input sets the flag on every cycle it is present. A status clear therefore only sticks once the input is low.
- R6: With edge-select=0 and polarity=0, a low input sets the flag. Because every register resets to 0, a line whose input stays low sets its flag soon after reset.
- R7: Flags latch even when the line's enable bit is 0. Such a line does not raise an interrupt request.
- R8: `irq_o[0]` is the OR of (status AND enable) over bits 0-15. `irq_o[1]` is the same OR over bits 16-31. Both follow a change of enable or status combinationally.
- R9: Writing offset 4 clears each status bit written as 1 and leaves bits written as 0 alone. If an event arrives in the same cycle as the clear, the flag ends up set.
- R10: Configuration and enable registers read back the value last written.
- R11: A status clear issued after a line is reconfigured removes a flag latched under the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous GPIO inputs, line n on bit n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | 2 | Interrupt request per port (bit 0 port A, bit 1 port B) |

## Verification
A pin change driven at a falling edge reaches the second synchronizer flop at the second rising edge. The flag and the interrupt request follow at the third rising edge. The bench therefore reads status after exactly two rising edges to confirm the flag is still clear, and after the third to confirm it is set. Register writes and status clears take effect at the rising edge that samples the strobe, and `irq_o` tracks enable and status with no added delay. Every read is made half a cycle after the edge under test. The clear that collides with an event is timed so that the strobe is sampled at that same third edge.

// File: rtl/gpio_event_irq.sv
module gpio_event_irq #(
  parameter int PINS_PER_PORT = 16,
  parameter int PORTS         = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [PORTS*PINS_PER_PORT-1:0]     pin_i,
  input  logic                               bus_we,
  input  logic [2:0]                         bus_addr,
  input  logic [PORTS*PINS_PER_PORT-1:0]     bus_wdata,
  output logic [PORTS*PINS_PER_PORT-1:0]     bus_rdata,
  output logic [PORTS-1:0]                   irq_o
);
  localparam int LINES = PORTS * PINS_PER_PORT;
  localparam logic [2:0] A_EDGE = 3'd0, A_BOTH = 3'd1, A_POL = 3'd2,
                         A_EN = 3'd3, A_STAT = 3'd4;

  logic [LINES-1:0] meta_q, sync_q, prev_q;
  logic [LINES-1:0] edge_q, both_q, pol_q, en_q, flag_q;
  logic [LINES-1:0] rise, fall, hit, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
  assign hit  = (edge_q & both_q & (rise | fall))
              | (edge_q & ~both_q & ((pol_q & rise) | (~pol_q & fall)))
              | (~edge_q & ((pol_q & sync_q) | (~pol_q & ~sync_q)));
  assign clr  = (bus_we && bus_addr == A_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      both_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (bus_we && bus_addr == A_EDGE) edge_q <= bus_wdata;
      if (bus_we && bus_addr == A_BOTH) both_q <= bus_wdata;
      if (bus_we && bus_addr == A_POL)  pol_q  <= bus_wdata;
      if (bus_we && bus_addr == A_EN)   en_q   <= bus_wdata;
      flag_q <= (flag_q & ~clr) | hit;
    end
  end

  always_comb begin
    case (bus_addr)
      A_EDGE:  bus_rdata = edge_q;
      A_BOTH:  bus_rdata = both_q;
      A_POL:   bus_rdata = pol_q;
      A_EN:    bus_rdata = en_q;
      A_STAT:  bus_rdata = flag_q;
      default: bus_rdata = '0;
    endcase
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign irq_o[p] = |(flag_q[p*PINS_PER_PORT +: PINS_PER_PORT] &
                        en_q[p*PINS_PER_PORT +: PINS_PER_PORT]);
  end
endmodule

// File: rtl/gpio_event_irq_sva.sv
module gpio_event_irq_sva #(
  parameter int PINS_PER_PORT = 16,
  parameter int PORTS         = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_we,
  input logic [2:0]                     bus_addr,
  input logic [PORTS*PINS_PER_PORT-1:0] sync_q,
  input logic [PORTS*PINS_PER_PORT-1:0] prev_q,
  input logic [PORTS*PINS_PER_PORT-1:0] edge_q,
  input logic [PORTS*PINS_PER_PORT-1:0] pol_q,
  input logic [PORTS*PINS_PER_PORT-1:0] en_q,
  input logic [PORTS*PINS_PER_PORT-1:0] flag_q,
  input logic [PORTS-1:0]               irq_o
);
  logic [PORTS*PINS_PER_PORT-1:0] high_lvl;
  assign high_lvl = ~edge_q & pol_q & sync_q;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (irq_o == '0 && flag_q == '0));

  assert_no_edge_no_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q == prev_q) |=> ((flag_q & ~$past(flag_q) & $past(edge_q)) == '0));

  assert_level_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(high_lvl)) == $past(high_lvl)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == 3'd4) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  for (genvar p = 0; p < PORTS; p++) begin : g_chk
    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[p*PINS_PER_PORT +: PINS_PER_PORT] == '0) |-> !irq_o[p]);
    assert_irq_has_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[p] |-> (flag_q[p*PINS_PER_PORT +: PINS_PER_PORT] != '0));
  end
endmodule

bind gpio_event_irq gpio_event_irq_sva #(.PINS_PER_PORT(PINS_PER_PORT), .PORTS(PORTS)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .sync_q(sync_q), .prev_q(prev_q), .edge_q(edge_q), .pol_q(pol_q),
  .en_q(en_q), .flag_q(flag_q), .irq_o(irq_o)
);

// File: tb/gpio_event_irq_tb.sv
module gpio_event_irq_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] pin_i = '0;
  logic        bus_we = 0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_o;
  int checks = 0, errors = 0;
  logic [31:0] edge_s, both_s, pol_s, en_s;

  gpio_event_irq u_dut (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cfg();
    wr(3'd0, edge_s); wr(3'd1, both_s); wr(3'd2, pol_s); wr(3'd3, en_s);
  endtask

  function automatic logic [31:0] bit_of(input int i);
    return 32'h1 << i;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); check("R1 reset read", v, '0);
    end
    check("R1 reset irq", {30'b0, irq_o}, '0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    edge_s = 32'hA5A5_0F0F; both_s = 32'h1234_5678; pol_s = 32'hFFFF_0000; en_s = 32'h0F0F_F0F0;
    cfg();
    rd(3'd0, v); check("R10 edge readback", v, edge_s);
    rd(3'd1, v); check("R10 both readback", v, both_s);
    rd(3'd2, v); check("R10 pol readback", v, pol_s);
    rd(3'd3, v); check("R10 en readback", v, en_s);
    rd(3'd5, v); check("R1 unused offset", v, '0);
  endtask

  task automatic t_reconfig_clear();
    logic [31:0] v;
    edge_s = '1; both_s = '0; pol_s = '1; en_s = '0;
    cfg(); step(3);
    rd(3'd4, v); check("R6 low-level flags after reset", v, '1);
    wr(3'd4, '1); step(1);
    rd(3'd4, v); check("R11 stale flags cleared", v, '0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    pin_i[3] = 1;
    step(2); rd(3'd4, v); check("R2 not yet at edge 2", v & bit_of(3), '0);
    step(1); rd(3'd4, v); check("R2 rise at edge 3", v & bit_of(3), bit_of(3));
    wr(3'd4, bit_of(3));
    pin_i[3] = 0; step(4);
    rd(3'd4, v); check("R2 fall ignored", v & bit_of(3), '0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    pol_s[20] = 0; cfg();
    pin_i[20] = 1; step(4);
    rd(3'd4, v); check("R3 rise ignored", v & bit_of(20), '0);
    pin_i[20] = 0;
    step(2); rd(3'd4, v); check("R3 not yet at edge 2", v & bit_of(20), '0);
    step(1); rd(3'd4, v); check("R3 fall at edge 3", v & bit_of(20), bit_of(20));
    wr(3'd4, bit_of(20));
  endtask

  task automatic t_both();
    logic [31:0] v;
    both_s[5] = 1; pol_s[5] = 0; cfg();
    pin_i[5] = 1; step(3);
    rd(3'd4, v); check("R4 rise sets", v & bit_of(5), bit_of(5));
    wr(3'd4, bit_of(5));
    rd(3'd4, v); check("R4 cleared", v & bit_of(5), '0);
    pin_i[5] = 0; step(3);
    rd(3'd4, v); check("R4 fall sets", v & bit_of(5), bit_of(5));
    wr(3'd4, bit_of(5));
  endtask

  task automatic t_level_high();
    logic [31:0] v;
    edge_s[8] = 0; pol_s[8] = 1; cfg();
    pin_i[8] = 1; step(3);
    rd(3'd4, v); check("R5 high level sets", v & bit_of(8), bit_of(8));
    wr(3'd4, bit_of(8));
    rd(3'd4, v); check("R5 clear while high resets", v & bit_of(8), bit_of(8));
    pin_i[8] = 0; step(4);
    wr(3'd4, bit_of(8));
    rd(3'd4, v); check("R5 clear after low sticks", v & bit_of(8), '0);
  endtask

  task automatic t_level_low();
    logic [31:0] v;
    edge_s[24] = 0; pol_s[24] = 0; cfg(); step(1);
    rd(3'd4, v); check("R6 low level sets", v & bit_of(24), bit_of(24));
    pin_i[24] = 1; step(4);
    wr(3'd4, bit_of(24));
    rd(3'd4, v); check("R6 cleared once high", v & bit_of(24), '0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    en_s = '0; wr(3'd3, en_s);
    pin_i[1] = 1; step(3);
    rd(3'd4, v); check("R7 masked flag latches", v & bit_of(1), bit_of(1));
    check("R7 masked no irq", {30'b0, irq_o}, '0);
    en_s[1] = 1; wr(3'd3, en_s); #1;
    check("R8 port A irq only", {30'b0, irq_o}, 32'h1);
    pin_i[17] = 1; step(3); #1;
    check("R8 port B masked", {30'b0, irq_o}, 32'h1);
    en_s[17] = 1; wr(3'd3, en_s); #1;
    check("R8 both ports", {30'b0, irq_o}, 32'h3);
    wr(3'd4, bit_of(1)); #1;
    check("R8 port A cleared", {30'b0, irq_o}, 32'h2);
    rd(3'd4, v); check("R9 zero bits untouched", v & bit_of(17), bit_of(17));
    wr(3'd4, bit_of(17)); #1;
    check("R8 all quiet", {30'b0, irq_o}, '0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pin_i[2] = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(3'd4, bit_of(2));
    rd(3'd4, v); check("R9 event beats clear", v & bit_of(2), bit_of(2));
    wr(3'd4, bit_of(2));
    rd(3'd4, v); check("R9 later clear works", v & bit_of(2), '0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1;
    t_regs();
    t_reconfig_clear();
    t_rise();
    t_fall();
    t_both();
    t_level_high();
    t_level_low();
    t_enable();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule